// File: doc/BRIEF.md
# Exception Vector and Cause Unit

This unit sits next to a simple in-order RISC pipeline and performs exception entry. When the pipeline raises a single-cycle fault request, the unit does four things. It encodes the fault into a 5-bit exception code. It picks the handler address from a base and a fault-dependent offset. It spreads the fault details over a small set of privileged registers. It then sends the pipeline a one-cycle redirect carrying the handler address.

The privileged registers are held inside the unit and are reached through a plain register-file port. Reads are combinational and writes are synchronous. Software uses this port to set the vector base, the boot-vector select bit and the interrupt-vector select bit. It also uses it to read back the saved fault state. A fault arriving in a cycle always wins over a software write in that same cycle.

Register indices on the port are: 0 status, 1 cause, 2 saved PC, 3 bad address, 4 vector base, 5 translation high word, 6 translation context. Status bit 0 is the exception-level flag and status bit 1 is the boot-vector select. Cause bits [4:0] hold the exception code, cause bit 8 selects the dedicated interrupt vector, and cause bits [13:12] hold the coprocessor number.

Top module: `exc_entry_unit`

## Requirements
- R1: The fault kind input (0 interrupt, 1 page modified, 2 refill miss, 3 invalid page, 4 address error, 5 instruction bus error, 6 data bus error, 7 syscall, 8 breakpoint, 9 reserved instruction, 10 coprocessor unusable, 11 overflow, 12 trap, 13 coprocessor-2, 14 media extension, 15 watch, 16 machine check, 17 thread, 18 cache error) is encoded into cause[4:0] as follows. Interrupt is 0, breakpoint 9, overflow 12, trap 13, syscall 8 and reserved instruction 10. The bus errors are 6 (instruction) and 7 (data). Coprocessor unusable is 11 and coprocessor-2 is 18. Machine check is 24, media extension 22, watch 23, thread 25 and cache error 30.
- R2: Address errors report code 5 on a store and 4 on a load. Refill-miss and invalid-page faults report 3 on a store and 2 on a load. A page-modified fault always reports 1.
- R3: The vector base is the vector-base register when status bit 1 is 0, and 0xBFC00200 when it is 1.
- R4: For an interrupt, the offset is 0x200 when cause bit 8 is set and 0x180 when it is clear. Every fault kind other than interrupt and refill miss uses offset 0x180.
- R5: A refill-miss fault uses offset 0x000 when status bit 0 is clear before entry, and 0x180 when it is set.
- R6: Address-error faults and the three translation faults (kinds 1 to 3) write the faulting virtual address into the bad-address register. All other kinds leave that register unchanged.
- R7: Translation faults load the translation high word as follows: bits [7:0] take the address-space ID, bits [9:8] take the low 2 bits of the 21-bit page number, bits [31:13] take the page number shifted right by 2, and all other bits are zero. They also write the page number shifted right by 2 into context bits [22:4] and keep the other context bits.
- R8: A coprocessor-unusable fault writes the requesting coprocessor number into cause bits [13:12].
- R9: On every fault request, the following all happen at the next clock edge. The code is stored, the fault PC goes to the saved-PC register, status bit 0 is set, and the redirect strobe is high for exactly one cycle with the computed vector.
- R10: A fault request in the same cycle as a software write discards that write.
- R11: Reset sets status to 0x2 (boot select set, exception level clear), clears all other registers and holds the redirect strobe low.
- R12: A software write takes effect at the next edge. A read returns the addressed register combinationally, and index 7 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_valid | input | 1 | One-cycle fault request |
| flt_kind | input | 5 | Fault kind (see R1) |
| flt_store | input | 1 | 1 = faulting access was a store |
| flt_pc | input | 32 | PC of the faulting instruction |
| flt_vaddr | input | 32 | Faulting virtual address |
| flt_asid | input | 8 | Address-space ID of the access |
| flt_vpn | input | 21 | Virtual page number of the access |
| flt_cop | input | 2 | Coprocessor number for an unusable fault |
| sw_we | input | 1 | Register write enable |
| sw_addr | input | 3 | Register index |
| sw_wdata | input | 32 | Register write data |
| sw_rdata | output | 32 | Register read data |
| redir_valid | output | 1 | Redirect strobe |
| redir_pc | output | 32 | Handler address |

## Verification
The assertions assume that a fault request is held for one cycle per exception. They also assume that the vector base and select bits are stable across the edge where a fault is taken, so the registered vector can be compared with the state seen before entry. The directed tasks drive every input on the falling edge and issue each fault as a single-cycle pulse. They reprogram status, cause and vector base only through separate write cycles, except in the deliberate collision case for R10. Every address and page number used fits within its port width.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int XLEN     = 32;
    localparam int ASID_W   = 8;
    localparam int VPN_W    = 21;
    localparam int VPN2_W   = VPN_W - 2;
    localparam int CODE_W   = 5;
    localparam int KIND_W   = 5;
    localparam int COP_W    = 2;
    localparam int RIDX_W   = 3;
    localparam int NREG     = 7;

    localparam int ST_EXL      = 0;
    localparam int ST_BEV      = 1;
    localparam int CA_IV       = 8;
    localparam int CA_CE_LSB   = 12;
    localparam int EH_X_LSB    = 8;
    localparam int EH_VPN2_LSB = XLEN - VPN2_W;
    localparam int CX_VPN2_LSB = 4;

    localparam logic [XLEN-1:0] BOOT_BASE  = 32'hBFC0_0200;
    localparam logic [XLEN-1:0] OFS_GEN    = 32'h0000_0180;
    localparam logic [XLEN-1:0] OFS_IVEC   = 32'h0000_0200;
    localparam logic [XLEN-1:0] OFS_REFILL = 32'h0000_0000;

    typedef enum logic [KIND_W-1:0] {
        K_INT = 5'd0, K_TLB_MOD = 5'd1, K_REFILL = 5'd2, K_TLB_INV = 5'd3,
        K_ADDR = 5'd4, K_IBUS = 5'd5, K_DBUS = 5'd6, K_SYS = 5'd7,
        K_BRK = 5'd8, K_RSVD = 5'd9, K_COP = 5'd10, K_OVF = 5'd11,
        K_TRAP = 5'd12, K_COP2 = 5'd13, K_MEDIA = 5'd14, K_WATCH = 5'd15,
        K_MCHK = 5'd16, K_THREAD = 5'd17, K_CACHE = 5'd18
    } fault_kind_e;

    typedef enum logic [RIDX_W-1:0] {
        RG_STATUS = 3'd0, RG_CAUSE = 3'd1, RG_EPC = 3'd2, RG_BAD = 3'd3,
        RG_EBASE = 3'd4, RG_EHI = 3'd5, RG_CTX = 3'd6
    } reg_idx_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              tlb;
        logic              wr_bad;
        logic              wr_ce;
    } fault_info_t;

    function automatic logic [CODE_W-1:0] exc_code(fault_kind_e k, logic st);
        case (k)
            K_INT:     return 5'd0;
            K_TLB_MOD: return 5'd1;
            K_REFILL,
            K_TLB_INV: return st ? 5'd3 : 5'd2;
            K_ADDR:    return st ? 5'd5 : 5'd4;
            K_IBUS:    return 5'd6;
            K_DBUS:    return 5'd7;
            K_SYS:     return 5'd8;
            K_BRK:     return 5'd9;
            K_RSVD:    return 5'd10;
            K_COP:     return 5'd11;
            K_OVF:     return 5'd12;
            K_TRAP:    return 5'd13;
            K_COP2:    return 5'd18;
            K_MEDIA:   return 5'd22;
            K_WATCH:   return 5'd23;
            K_MCHK:    return 5'd24;
            K_THREAD:  return 5'd25;
            K_CACHE:   return 5'd30;
            default:   return 5'd10;
        endcase
    endfunction

    function automatic logic is_tlb(fault_kind_e k);
        return (k == K_TLB_MOD) || (k == K_REFILL) || (k == K_TLB_INV);
    endfunction
endpackage

// File: rtl/exc_cause_enc.sv
module exc_cause_enc
    import exc_pkg::*;
(
    input  fault_kind_e kind,
    input  logic        store,
    output fault_info_t info
);
    always_comb begin
        info.code   = exc_code(kind, store);
        info.tlb    = is_tlb(kind);
        info.wr_bad = is_tlb(kind) || (kind == K_ADDR);
        info.wr_ce  = (kind == K_COP);
    end
endmodule

// File: rtl/exc_vec_sel.sv
module exc_vec_sel
    import exc_pkg::*;
(
    input  fault_kind_e     kind,
    input  logic            bev,
    input  logic            exl,
    input  logic            iv,
    input  logic [XLEN-1:0] ebase,
    output logic [XLEN-1:0] vector
);
    logic [XLEN-1:0] base, ofs;

    always_comb begin
        base = bev ? BOOT_BASE : ebase;
        unique case (kind)
            K_INT:    ofs = iv  ? OFS_IVEC : OFS_GEN;
            K_REFILL: ofs = exl ? OFS_GEN  : OFS_REFILL;
            default:  ofs = OFS_GEN;
        endcase
        vector = base + ofs;
    end
endmodule

// File: rtl/exc_cp_regs.sv
module exc_cp_regs
    import exc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flt_valid,
    input  fault_info_t       info,
    input  logic [XLEN-1:0]   flt_pc,
    input  logic [XLEN-1:0]   flt_vaddr,
    input  logic [ASID_W-1:0] flt_asid,
    input  logic [VPN_W-1:0]  flt_vpn,
    input  logic [COP_W-1:0]  flt_cop,
    input  logic              sw_we,
    input  logic [RIDX_W-1:0] sw_addr,
    input  logic [XLEN-1:0]   sw_wdata,
    output logic [XLEN-1:0]   sw_rdata,
    output logic [XLEN-1:0]   status_o,
    output logic [XLEN-1:0]   cause_o,
    output logic [XLEN-1:0]   ebase_o
);
    logic [XLEN-1:0] regs_q [NREG];
    logic [XLEN-1:0] regs_d [NREG];
    logic [VPN2_W-1:0] vpn2;

    assign vpn2 = flt_vpn[VPN_W-1:2];

    always_comb begin
        for (int i = 0; i < NREG; i++) regs_d[i] = regs_q[i];
        if (flt_valid) begin
            regs_d[RG_STATUS][ST_EXL]        = 1'b1;
            regs_d[RG_CAUSE][CODE_W-1:0]     = info.code;
            if (info.wr_ce)
                regs_d[RG_CAUSE][CA_CE_LSB +: COP_W] = flt_cop;
            regs_d[RG_EPC] = flt_pc;
            if (info.wr_bad) regs_d[RG_BAD] = flt_vaddr;
            if (info.tlb) begin
                regs_d[RG_EHI] = '0;
                regs_d[RG_EHI][ASID_W-1:0]            = flt_asid;
                regs_d[RG_EHI][EH_X_LSB +: 2]         = flt_vpn[1:0];
                regs_d[RG_EHI][EH_VPN2_LSB +: VPN2_W] = vpn2;
                regs_d[RG_CTX][CX_VPN2_LSB +: VPN2_W] = vpn2;
            end
        end else if (sw_we) begin
            for (int i = 0; i < NREG; i++)
                if (sw_addr == RIDX_W'(i)) regs_d[i] = sw_wdata;
        end
    end

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) regs_q[g] <= (g == RG_STATUS) ? (XLEN'(1) << ST_BEV) : '0;
                else     regs_q[g] <= regs_d[g];
            end
        end
    endgenerate

    always_comb begin
        sw_rdata = '0;
        for (int i = 0; i < NREG; i++)
            if (sw_addr == RIDX_W'(i)) sw_rdata = regs_q[i];
    end

    assign status_o = regs_q[RG_STATUS];
    assign cause_o  = regs_q[RG_CAUSE];
    assign ebase_o  = regs_q[RG_EBASE];

    p_exl_set_r9: assert property (@(posedge clk) disable iff (rst)
        flt_valid |=> regs_q[RG_STATUS][ST_EXL]);
    p_epc_save_r9: assert property (@(posedge clk) disable iff (rst)
        flt_valid |=> regs_q[RG_EPC] == $past(flt_pc));
    p_bad_keep_r6: assert property (@(posedge clk) disable iff (rst)
        (flt_valid && !info.wr_bad) |=> $stable(regs_q[RG_BAD]));
    p_fault_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (flt_valid && sw_we && sw_addr == RG_EBASE) |=> $stable(regs_q[RG_EBASE]));
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flt_valid,
    input  logic [KIND_W-1:0] flt_kind,
    input  logic              flt_store,
    input  logic [XLEN-1:0]   flt_pc,
    input  logic [XLEN-1:0]   flt_vaddr,
    input  logic [ASID_W-1:0] flt_asid,
    input  logic [VPN_W-1:0]  flt_vpn,
    input  logic [COP_W-1:0]  flt_cop,
    input  logic              sw_we,
    input  logic [RIDX_W-1:0] sw_addr,
    input  logic [XLEN-1:0]   sw_wdata,
    output logic [XLEN-1:0]   sw_rdata,
    output logic              redir_valid,
    output logic [XLEN-1:0]   redir_pc
);
    fault_kind_e     kind;
    fault_info_t     info;
    logic [XLEN-1:0] status, cause, ebase, vector;

    assign kind = fault_kind_e'(flt_kind);

    exc_cause_enc u_enc (.kind(kind), .store(flt_store), .info(info));

    exc_vec_sel u_vec (
        .kind(kind), .bev(status[ST_BEV]), .exl(status[ST_EXL]),
        .iv(cause[CA_IV]), .ebase(ebase), .vector(vector)
    );

    exc_cp_regs u_regs (
        .clk(clk), .rst(rst), .flt_valid(flt_valid), .info(info),
        .flt_pc(flt_pc), .flt_vaddr(flt_vaddr), .flt_asid(flt_asid),
        .flt_vpn(flt_vpn), .flt_cop(flt_cop), .sw_we(sw_we),
        .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .status_o(status), .cause_o(cause), .ebase_o(ebase)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            redir_valid <= 1'b0;
            redir_pc    <= '0;
        end else begin
            redir_valid <= flt_valid;
            if (flt_valid) redir_pc <= vector;
        end
    end

    p_redir_rise_r9: assert property (@(posedge clk) disable iff (rst)
        flt_valid |=> redir_valid);
    p_redir_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !flt_valid |=> !redir_valid);
    p_refill_boot_r5: assert property (@(posedge clk) disable iff (rst)
        (flt_valid && kind == K_REFILL && !status[ST_EXL] && status[ST_BEV])
        |=> redir_pc == BOOT_BASE);
    p_mod_code_r2: assert property (@(posedge clk) disable iff (rst)
        (flt_valid && kind == K_TLB_MOD) |=> cause[CODE_W-1:0] == 5'd1);
endmodule

// File: tb/exc_entry_unit_tb_top.sv
module exc_entry_unit_tb_top;
    import exc_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              flt_valid = 1'b0;
    logic [KIND_W-1:0] flt_kind = '0;
    logic              flt_store = 1'b0;
    logic [XLEN-1:0]   flt_pc = '0;
    logic [XLEN-1:0]   flt_vaddr = '0;
    logic [ASID_W-1:0] flt_asid = '0;
    logic [VPN_W-1:0]  flt_vpn = '0;
    logic [COP_W-1:0]  flt_cop = '0;
    logic              sw_we = 1'b0;
    logic [RIDX_W-1:0] sw_addr = '0;
    logic [XLEN-1:0]   sw_wdata = '0;
    logic [XLEN-1:0]   sw_rdata;
    logic              redir_valid;
    logic [XLEN-1:0]   redir_pc;

    int total = 0;
    int bad = 0;
    logic            got_v;
    logic [XLEN-1:0] got_pc;

    always #10 clk = ~clk;

    exc_entry_unit dut_i (.*);

    task automatic chk(input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp,
                       input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic logic [4:0] ref_code(int k, logic st);
        case (k)
            0: return 0;   1: return 1;
            2, 3: return st ? 3 : 2;
            4: return st ? 5 : 4;
            5: return 6;   6: return 7;   7: return 8;   8: return 9;
            9: return 10;  10: return 11; 11: return 12; 12: return 13;
            13: return 18; 14: return 22; 15: return 23; 16: return 24;
            17: return 25; default: return 30;
        endcase
    endfunction

    task automatic wr(input int a, input logic [XLEN-1:0] d);
        @(negedge clk);
        sw_we = 1'b1; sw_addr = RIDX_W'(a); sw_wdata = d;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [XLEN-1:0] d);
        @(negedge clk);
        sw_addr = RIDX_W'(a);
        #1 d = sw_rdata;
    endtask

    task automatic fire(input int k, input logic st, input logic [31:0] pc,
                        input logic [31:0] va, input logic [7:0] asid,
                        input logic [20:0] vpn, input logic [1:0] cop);
        @(negedge clk);
        flt_valid = 1'b1; flt_kind = KIND_W'(k); flt_store = st; flt_pc = pc;
        flt_vaddr = va; flt_asid = asid; flt_vpn = vpn; flt_cop = cop;
        @(posedge clk);
        #1 got_v = redir_valid; got_pc = redir_pc;
        @(negedge clk);
        flt_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [XLEN-1:0] d;
        chk({31'b0, redir_valid}, 0, "R11 redirect low after reset");
        rd(0, d); chk(d, 32'h2, "R11 status reset value");
        rd(1, d); chk(d, 0, "R11 cause reset value");
        rd(4, d); chk(d, 0, "R11 vector base reset value");
    endtask

    task automatic t_regport();
        logic [XLEN-1:0] d;
        wr(4, 32'h8000_0000);
        rd(4, d); chk(d, 32'h8000_0000, "R12 vector base write/read");
        rd(7, d); chk(d, 0, "R12 unused index reads zero");
    endtask

    task automatic t_boot_base();
        fire(7, 0, 32'h100, 0, 0, 0, 0);
        chk({31'b0, got_v}, 1, "R3 redirect on boot base");
        chk(got_pc, 32'hBFC0_0380, "R3 boot base plus 0x180");
        @(posedge clk); #1;
        chk({31'b0, redir_valid}, 0, "R9 strobe lasts one cycle");
    endtask

    task automatic t_all_codes();
        logic [XLEN-1:0] d, exp_pc;
        for (int k = 0; k < 19; k++) begin
            wr(0, 32'h0);
            wr(1, 32'h0);
            fire(k, 0, 32'h4000 + 32'(k) * 4, 32'h10, 0, 0, 0);
            exp_pc = (k == 2) ? 32'h8000_0000 : 32'h8000_0180;
            chk(got_pc, exp_pc, $sformatf("R1 R4 R5 vector for kind %0d", k));
            rd(1, d); chk({27'b0, d[4:0]}, {27'b0, ref_code(k, 0)},
                          $sformatf("R1 code for kind %0d", k));
            rd(2, d); chk(d, 32'h4000 + 32'(k) * 4, "R9 saved PC");
            rd(0, d); chk({31'b0, d[0]}, 1, "R9 exception level set");
        end
    endtask

    task automatic t_interrupt();
        wr(0, 0); wr(1, 32'h100);
        fire(0, 0, 0, 0, 0, 0, 0);
        chk(got_pc, 32'h8000_0200, "R4 interrupt with vector select set");
        wr(0, 0); wr(1, 0);
        fire(0, 0, 0, 0, 0, 0, 0);
        chk(got_pc, 32'h8000_0180, "R4 interrupt with vector select clear");
    endtask

    task automatic t_translation();
        logic [XLEN-1:0] d;
        wr(0, 0); wr(3, 0); wr(6, 32'h8000_0003);
        fire(2, 1, 32'h300, 32'h1234_5678, 8'h5A, 21'h12345, 0);
        chk(got_pc, 32'h8000_0000, "R5 refill with level clear");
        rd(1, d); chk({27'b0, d[4:0]}, 3, "R2 refill store code");
        rd(3, d); chk(d, 32'h1234_5678, "R6 bad address on refill");
        rd(5, d); chk(d, (32'h48D1 << 13) | (32'h1 << 8) | 32'h5A, "R7 high word");
        rd(6, d); chk(d, 32'h8000_0003 | (32'h48D1 << 4), "R7 context");
        fire(2, 0, 32'h304, 32'h10, 0, 0, 0);
        chk(got_pc, 32'h8000_0180, "R5 refill with level set");
        rd(1, d); chk({27'b0, d[4:0]}, 2, "R2 refill load code");
        fire(3, 1, 0, 0, 0, 0, 0);
        rd(1, d); chk({27'b0, d[4:0]}, 3, "R2 invalid store code");
        fire(1, 1, 0, 0, 0, 0, 0);
        rd(1, d); chk({27'b0, d[4:0]}, 1, "R2 modified ignores store flag");
    endtask

    task automatic t_addr_err();
        logic [XLEN-1:0] d;
        fire(4, 1, 0, 32'hCAFE_0001, 0, 0, 0);
        rd(1, d); chk({27'b0, d[4:0]}, 5, "R2 address error store");
        rd(3, d); chk(d, 32'hCAFE_0001, "R6 bad address on address error");
        fire(4, 0, 0, 32'hCAFE_0002, 0, 0, 0);
        rd(1, d); chk({27'b0, d[4:0]}, 4, "R2 address error load");
        fire(7, 0, 0, 32'hDEAD_BEEF, 0, 0, 0);
        rd(3, d); chk(d, 32'hCAFE_0002, "R6 syscall keeps bad address");
    endtask

    task automatic t_cop();
        logic [XLEN-1:0] d;
        wr(1, 0);
        fire(10, 0, 0, 0, 0, 0, 2'd2);
        rd(1, d); chk({30'b0, d[13:12]}, 2, "R8 coprocessor number");
        chk({27'b0, d[4:0]}, 11, "R1 coprocessor unusable code");
    endtask

    task automatic t_collision();
        logic [XLEN-1:0] d;
        wr(0, 0);
        @(negedge clk);
        flt_valid = 1'b1; flt_kind = 5'd7; sw_we = 1'b1; sw_addr = 3'd4;
        sw_wdata = 32'h1111_0000;
        @(negedge clk);
        flt_valid = 1'b0; sw_we = 1'b0;
        rd(4, d); chk(d, 32'h8000_0000, "R10 base write dropped on fault");
        wr(0, 0);
        @(negedge clk);
        flt_valid = 1'b1; sw_we = 1'b1; sw_addr = 3'd0; sw_wdata = 32'h0;
        @(negedge clk);
        flt_valid = 1'b0; sw_we = 1'b0;
        rd(0, d); chk({31'b0, d[0]}, 1, "R10 status write dropped on fault");
    endtask

    initial begin
        #(20 * 150000);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_boot_base();
        t_regport();
        t_all_codes();
        t_interrupt();
        t_translation();
        t_addr_err();
        t_cop();
        t_collision();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule